// File: doc/BRIEF.md
# Clock-Synthesis Loop Configuration Registers

This block holds the software-visible programming of a clock-synthesis loop: a reference divider code, a VCO range value, and a control register. The control register holds the loop enable, the base-clock select, automatic mode, the lock interrupt enable and the lock interrupt flag. Software uses a simple 8-bit register port with a write strobe and a combinational read. The block drives the divider code, the range value, the loop enable and the base-clock select to the analog loop and to the clock multiplexer, which sit outside it.

The block keeps that programming consistent. While the loop runs, the divider and range values are frozen. A zero divider code reaches the loop as a divide-by-one. The loop clock cannot be picked as the base clock while the range value is zero. The lock indication comes from the analog side and is resynchronised into this domain. In automatic mode, every change of lock status raises a flag and can raise an interrupt. Software then reads the synchronised lock bit to learn whether lock was gained or lost.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset the control register reads 0x00 with `lock_in` low, the range register reads 0x40, the divider register reads 0x01, `ref_div_o` is 1, `vco_range_o` is 0x40, and `base_clk_sel_o`, `pll_en_o` and `irq_o` are 0.
- R2: The divider register is at address 2. It stores write data bits 3:0, and bits 7:4 always read as 0.
- R3: `ref_div_o` equals the stored divider code, except that a stored code of 0 drives `ref_div_o` to 1.
- R4: A write to the divider register has no effect while the loop enable (control bit 5, address 0) is set.
- R5: The range register is at address 1 and holds all 8 bits. A write to it has no effect while the loop enable is set.
- R6: The base-clock select is control bit 4 and drives `base_clk_sel_o`. Writing it as 1 is refused while the range register holds 0. Writing it as 0 always takes effect.
- R7: When automatic mode (control bit 3) is set, the flag (control bit 6) becomes set whenever the synchronised lock status changes, whether lock is gained or lost and whatever the interrupt enable holds. The flag is readable on the third rising clock edge after `lock_in` changes.
- R8: `irq_o` is high exactly while the flag and the interrupt enable (control bit 7) are both set.
- R9: With automatic mode clear, the flag reads as 0, lock changes do not set it, and `irq_o` stays low.
- R10: A control write with bit 6 at 0 clears the flag. A control write with bit 6 at 1 neither sets nor clears it.
- R11: Control bit 0 reads the synchronised lock status, and control bits 2:1 read 0. Address 3 reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| lock_in | input | 1 | Lock indication from the analog loop, asynchronous |
| ref_div_o | output | 4 | Effective reference divider code |
| vco_range_o | output | 8 | VCO range value |
| pll_en_o | output | 1 | Loop enable |
| base_clk_sel_o | output | 1 | Selects the loop clock as base clock |
| irq_o | output | 1 | Lock-change interrupt request |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are valid on any cycle where `reg_wr` is high. They also assume that `lock_in`, although asynchronous, stays steady for several clock cycles after each change, so that every transition survives the synchroniser. The bench changes its inputs only at falling clock edges and holds `lock_in` for at least four cycles between changes. It never writes the control register in the same cycle that a lock change reaches the flag, so the ordering of a set and a clear in that cycle is not exercised.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
    parameter int REG_W   = 8;
    parameter int DIV_W   = 4;
    parameter int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RANGE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DIV   = 2'd2;

    // control register bit positions
    localparam int CB_IRQEN = 7;
    localparam int CB_FLAG  = 6;
    localparam int CB_EN    = 5;
    localparam int CB_BSEL  = 4;
    localparam int CB_AUTO  = 3;
    localparam int CB_LOCK  = 0;

    typedef struct packed {
        logic             irq_en;
        logic             flag;
        logic             loop_en;
        logic             base_sel;
        logic             auto_md;
        logic [REG_W-1:0] range;
        logic [DIV_W-1:0] div;
    } cfg_state_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_async,
    output logic lock_sync,
    output logic lock_change
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else begin
                    chain_q[i] <= (i == 0) ? lock_async : chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign lock_sync   = chain_q[STAGES-1];
    assign lock_change = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pll_div_decode.sv
module pll_div_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] code,
    output logic [W-1:0] eff
);
    always_comb begin
        eff = code;
        if (code == '0) begin
            eff = W'(1);
        end
    end
endmodule

// File: rtl/pll_reg_readmux.sv
module pll_reg_readmux
    import pll_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cfg_state_t        st,
    input  logic              lock_sync,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTL: begin
                rdata[CB_IRQEN] = st.irq_en;
                rdata[CB_FLAG]  = st.flag & st.auto_md;
                rdata[CB_EN]    = st.loop_en;
                rdata[CB_BSEL]  = st.base_sel;
                rdata[CB_AUTO]  = st.auto_md;
                rdata[CB_LOCK]  = lock_sync;
            end
            ADDR_RANGE: rdata = st.range;
            ADDR_DIV:   rdata[DIV_W-1:0] = st.div;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_cfg_pkg::*;
#(
    parameter logic [7:0] RANGE_RST   = 8'h40,
    parameter logic [3:0] DIV_RST     = 4'h1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             lock_in,
    output logic [DIV_W-1:0] ref_div_o,
    output logic [REG_W-1:0] vco_range_o,
    output logic             pll_en_o,
    output logic             base_clk_sel_o,
    output logic             irq_o
);
    cfg_state_t st_d, st_q;
    logic       lock_s;
    logic       lock_chg;

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_async (lock_in),
        .lock_sync  (lock_s),
        .lock_change(lock_chg)
    );

    always_comb begin
        logic wr_ctl, wr_rng, wr_div;
        st_d   = st_q;
        wr_ctl = reg_wr && (reg_addr == ADDR_CTL);
        wr_rng = reg_wr && (reg_addr == ADDR_RANGE);
        wr_div = reg_wr && (reg_addr == ADDR_DIV);

        if (wr_ctl) begin
            st_d.irq_en  = reg_wdata[CB_IRQEN];
            st_d.loop_en = reg_wdata[CB_EN];
            st_d.auto_md = reg_wdata[CB_AUTO];
            if (!reg_wdata[CB_BSEL]) begin
                st_d.base_sel = 1'b0;
            end else if (st_q.range != '0) begin
                st_d.base_sel = 1'b1;
            end
            if (!reg_wdata[CB_FLAG]) begin
                st_d.flag = 1'b0;
            end
        end
        if (wr_rng && !st_q.loop_en) begin
            st_d.range = reg_wdata;
        end
        if (wr_div && !st_q.loop_en) begin
            st_d.div = reg_wdata[DIV_W-1:0];
        end
        if (lock_chg && st_q.auto_md) begin
            st_d.flag = 1'b1;
        end
        if (!st_d.auto_md) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{irq_en: 1'b0, flag: 1'b0, loop_en: 1'b0, base_sel: 1'b0,
                      auto_md: 1'b0, range: RANGE_RST, div: DIV_RST};
        end else begin
            st_q <= st_d;
        end
    end

    pll_div_decode #(.W(DIV_W)) u_div (
        .code(st_q.div),
        .eff (ref_div_o)
    );

    pll_reg_readmux u_rd (
        .addr     (reg_addr),
        .st       (st_q),
        .lock_sync(lock_s),
        .rdata    (reg_rdata)
    );

    assign vco_range_o    = st_q.range;
    assign pll_en_o       = st_q.loop_en;
    assign base_clk_sel_o = st_q.base_sel;
    assign irq_o          = st_q.flag & st_q.irq_en & st_q.auto_md;
endmodule

// File: rtl/pll_cfg_regs_chk.sv
module pll_cfg_regs_chk
    import pll_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [DIV_W-1:0] ref_div_o,
    input logic [REG_W-1:0] vco_range_o,
    input logic             pll_en_o,
    input logic             base_clk_sel_o,
    input logic             irq_o
);
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div_o != '0);                                                   // R3

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en_o && reg_wr && reg_addr == ADDR_DIV) |=> $stable(ref_div_o)); // R4

    AST_RANGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en_o && reg_wr && reg_addr == ADDR_RANGE) |=> $stable(vco_range_o)); // R5

    AST_BSEL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTL && reg_wdata[CB_BSEL] && vco_range_o == '0
         && !base_clk_sel_o) |=> !base_clk_sel_o);                          // R6

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTL && !reg_wdata[CB_IRQEN]) |=> !irq_o); // R8
endmodule

bind pll_cfg_regs pll_cfg_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .ref_div_o     (ref_div_o),
    .vco_range_o   (vco_range_o),
    .pll_en_o      (pll_en_o),
    .base_clk_sel_o(base_clk_sel_o),
    .irq_o         (irq_o)
);

// File: tb/pll_cfg_regs_bench.sv
module pll_cfg_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lock_in = 1'b0;
    logic [3:0] ref_div_o;
    logic [7:0] vco_range_o;
    logic       pll_en_o;
    logic       base_clk_sel_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pll_cfg_regs u_pll_cfg_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_in(lock_in),
        .ref_div_o(ref_div_o), .vco_range_o(vco_range_o), .pll_en_o(pll_en_o),
        .base_clk_sel_o(base_clk_sel_o), .irq_o(irq_o)
    );

    // vector: {addr, write data, expected read-back of same address}
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {2'd2, 8'hF7, 8'h07},   // R2 upper bits dropped
        {2'd2, 8'h00, 8'h00},   // R3 zero code stored
        {2'd1, 8'h00, 8'h00},   // R5 range to zero
        {2'd0, 8'h10, 8'h00},   // R6 select refused
        {2'd1, 8'h25, 8'h25},   // R5
        {2'd0, 8'h10, 8'h10},   // R6 select accepted
        {2'd0, 8'h36, 8'h30},   // R11 bits 2:1 read 0, loop on
        {2'd1, 8'h99, 8'h25},   // R5 blocked
        {2'd2, 8'h0A, 8'h00},   // R4 blocked
        {2'd0, 8'h00, 8'h00},   // R6 deselect, loop off
        {2'd2, 8'h0A, 8'h0A},   // R4 unblocked
        {2'd3, 8'hFF, 8'h00}    // R11 empty address
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        rd(2'd0, v); check("R1 ctl", v, 8'h00);
        rd(2'd1, v); check("R1 range", v, 8'h40);
        rd(2'd2, v); check("R1 div", v, 8'h01);
        check("R1 ref_div_o", {4'h0, ref_div_o}, 8'h01);
        check("R1 vco_range_o", vco_range_o, 8'h40);
        check("R1 outs", {5'd0, base_clk_sel_o, pll_en_o, irq_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], v);
            check($sformatf("vector %0d (R2/R4/R5/R6/R11)", i), v, VEC[i][7:0]);
            if (i == 1) check("R3 zero code gives 1", {4'h0, ref_div_o}, 8'h01);
            if (i == 5) check("R6 base_clk_sel_o", {7'd0, base_clk_sel_o}, 8'h01);
            if (i == 7) check("R5 vco_range_o frozen", vco_range_o, 8'h25);
            if (i == 8) check("R4 ref_div_o frozen", {4'h0, ref_div_o}, 8'h01);
        end
        check("R3 ref_div_o", {4'h0, ref_div_o}, 8'h0A);

        // lock interrupt sequence
        wr(2'd0, 8'h08);                        // automatic mode on
        lock_in = 1'b1;
        cycles(2);
        rd(2'd0, v); check("R7 flag not yet", v, 8'h09);
        cycles(1);
        rd(2'd0, v); check("R7 flag on entry", v, 8'h49);
        check("R8 no irq without enable", {7'd0, irq_o}, 8'h00);
        wr(2'd0, 8'hC8);
        rd(2'd0, v); check("R10 write 1 keeps flag", v, 8'hC9);
        check("R8 irq", {7'd0, irq_o}, 8'h01);
        wr(2'd0, 8'h88);
        rd(2'd0, v); check("R10 flag cleared", v, 8'h89);
        check("R8 irq dropped", {7'd0, irq_o}, 8'h00);
        lock_in = 1'b0;
        cycles(3);
        rd(2'd0, v); check("R7 flag on exit", v, 8'hC8);
        check("R8 irq on exit", {7'd0, irq_o}, 8'h01);
        wr(2'd0, 8'h80);                        // automatic mode off
        rd(2'd0, v); check("R9 flag reads 0", v, 8'h80);
        check("R9 irq low", {7'd0, irq_o}, 8'h00);
        lock_in = 1'b1;
        cycles(4);
        rd(2'd0, v); check("R9 no flag on change", v, 8'h81);
        wr(2'd0, 8'hC0);
        rd(2'd0, v); check("R10 write 1 does not set", v, 8'h81);
        check("R9 irq still low", {7'd0, irq_o}, 8'h00);
        wr(2'd0, 8'h08);
        rd(2'd0, v); check("R7 no stale flag", v, 8'h09);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule